// File: doc/BRIEF.md
# Ping-Pong Cache Sequencer

This block schedules the traffic of a memory-based FFT engine that keeps a small single-port cache next to its processing engine. The main store is split into eight banks, and the sequencer issues eight operand addresses every cycle. Each pass over main memory covers two radix-8 stages. In the fill phase, eight words are read from main memory; the engine transforms them and the results go into one row of a 64-word cache. Once eight rows are full, the drain phase reads the cache column by column. The engine runs the second stage on that data, and the results go back to the main-memory locations they came from. Main memory therefore sees one read and one write per word per pair of stages.

Two main buffers alternate in role. One is the processing buffer the sequencer addresses. The other is free for sample input and output. The roles change when a transform completes. A one-cycle start pulse launches a transform, and a one-cycle done pulse marks its end. The arithmetic and the pipeline compensation of the engine sit outside this block; every command here applies to the cycle in which it is shown.

Top module: `ping_pong_cache_seq`

## Requirements
- R1: After reset the block is idle. `busy_o`, `done_o`, `fill_o`, `drain_o`, every memory and cache enable, and `proc_buf_o` are all 0.
- R2: A start pulse seen while idle makes the first fill cycle of stage 0 appear on the outputs in the next cycle. A start pulse seen while busy is ignored and changes no output.
- R3: While busy, every cycle is either fill or drain, never both. A fill cycle asserts `main_re_o` and `cache_we_o` only. A drain cycle asserts `cache_re_o` and `main_we_o` only. The phases alternate in runs of eight cycles, starting with fill.
- R4: In every busy cycle the eight lanes select eight distinct banks.
- R5: Take word index w and read it as base-8 digits (digit 0 is the lowest). It is stored in bank (sum of its digits) mod 8, at in-bank address w >> 3.
- R6: In pass p (p counts from 0), stage a = 2p uses digit NDIG-1-2p and stage b = 2p+1 uses digit NDIG-2-2p, with NDIG = ADDR_W/3. In fill cycle g of a block, lane k addresses the word whose stage-a digit is k and whose stage-b digit is g. In drain cycle g the two roles swap. The other digits are the same for all lanes and are fixed for the block. `stage_o` shows a in fill and b in drain.
- R7: Fill cycle g writes cache row g, with lane k going to column k (`cache_xpose_o` = 0). Drain cycle g reads with the transpose (`cache_xpose_o` = 1): lane k takes row k, column g. So the word each drain lane writes back is the one that produced that cache entry. `cache_row_o` equals g.
- R8: Within each pass, every word of the processing buffer is read exactly once and written exactly once.
- R9: A transform takes NDIG/2 × 2^ADDR_W / 8 read cycles and the same number of write cycles. That is half the main-memory cycles of one read and one write per stage.
- R10: One cycle after the last drain cycle, `done_o` is 1 for exactly one cycle and `busy_o` is 0. `proc_buf_o` toggles in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Launches a transform when idle |
| busy_o | output | 1 | Transform in progress |
| done_o | output | 1 | One-cycle completion pulse |
| proc_buf_o | output | 1 | Index of the main buffer in the processing role |
| fill_o | output | 1 | Fill phase active |
| drain_o | output | 1 | Drain phase active |
| stage_o | output | PASS_W+1 | Stage the engine is running |
| main_re_o | output | 1 | Main-memory read, all eight lanes |
| main_we_o | output | 1 | Main-memory write, all eight lanes |
| lane_bank_o | output | 8×3 | Bank per lane, lane k at bits [3k+2:3k] |
| lane_addr_o | output | 8×(ADDR_W-3) | In-bank address per lane |
| cache_re_o | output | 1 | Cache read |
| cache_we_o | output | 1 | Cache write |
| cache_row_o | output | 3 | Cache row or column index |
| cache_xpose_o | output | 1 | Cache accessed transposed |

## Verification
The bench runs two complete default-size transforms cycle by cycle. From each lane's bank and in-bank address it rebuilds the word index, and it keeps a cache model plus per-pass coverage maps. Several faults would show up there. A bank skew that fails to separate the lanes would produce bank collisions or rebuilt words that cannot occur. Swapping the stage digits would break the digit-per-lane check. A missing transpose in the drain phase would write results to words other than the ones that fed that cache slot. A wrong block or pass rollover would leave a word uncovered, or cover it twice, within a pass. A start pulse injected mid-transform shows whether a design restarts instead of ignoring it. The cycle in which the done pulse and the buffer toggle appear exposes off-by-one end detection.

// File: rtl/pps_pkg.sv
package pps_pkg;
    typedef enum logic {PH_FILL = 1'b0, PH_DRAIN = 1'b1} phase_e;
endpackage

// File: rtl/pps_ctrl.sv
module pps_ctrl
    import pps_pkg::*;
#(
    parameter int RDX_W  = 3,
    parameter int NPASS  = 2,
    parameter int PASS_W = 1,
    parameter int BLK_W  = 6,
    localparam int BLKC_W = (BLK_W > 0) ? BLK_W : 1
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              start_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              psel_o,
    output logic [PASS_W-1:0] pass_o,
    output logic [BLKC_W-1:0] blk_o,
    output phase_e            ph_o,
    output logic [RDX_W-1:0]  grp_o
);
    localparam logic [BLKC_W-1:0] BLK_LAST  = (BLK_W > 0) ? {BLKC_W{1'b1}} : '0;
    localparam logic [PASS_W-1:0] PASS_LAST = PASS_W'(NPASS - 1);

    typedef struct packed {
        logic              busy;
        logic              done;
        logic              psel;
        logic [PASS_W-1:0] pass;
        logic [BLKC_W-1:0] blk;
        phase_e            ph;
        logic [RDX_W-1:0]  grp;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (!st_q.busy) begin
            if (start_i) begin
                st_d.busy = 1'b1;
                st_d.pass = '0;
                st_d.blk  = '0;
                st_d.ph   = PH_FILL;
                st_d.grp  = '0;
            end
        end else begin
            st_d.grp = st_q.grp + 1'b1;
            if (&st_q.grp) begin
                if (st_q.ph == PH_FILL) begin
                    st_d.ph = PH_DRAIN;
                end else begin
                    st_d.ph = PH_FILL;
                    if (st_q.blk == BLK_LAST) begin
                        st_d.blk = '0;
                        if (st_q.pass == PASS_LAST) begin
                            st_d.busy = 1'b0;
                            st_d.done = 1'b1;
                            st_d.psel = ~st_q.psel;
                            st_d.pass = '0;
                        end else begin
                            st_d.pass = st_q.pass + 1'b1;
                        end
                    end else begin
                        st_d.blk = st_q.blk + 1'b1;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy_o = st_q.busy;
    assign done_o = st_q.done;
    assign psel_o = st_q.psel;
    assign pass_o = st_q.pass;
    assign blk_o  = st_q.blk;
    assign ph_o   = st_q.ph;
    assign grp_o  = st_q.grp;

    // R10: completion pulse lasts one cycle
    p_done_single_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o);
    // R10: buffer roles swap with the pulse
    p_swap_on_done_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> (psel_o != $past(psel_o)) && !busy_o);
    // R3: a phase run is not cut short
    p_phase_run_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy_o && !(&grp_o)) |=> (busy_o && $stable(ph_o)));
    // R2: start while busy does not restart the counters
    p_start_ignored_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy_o && start_i && grp_o == '0 && ph_o == PH_DRAIN) |=> (grp_o == RDX_W'(1)));
endmodule

// File: rtl/pps_cache_ctl.sv
module pps_cache_ctl
    import pps_pkg::*;
#(
    parameter int RDX_W = 3
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             busy_i,
    input  phase_e           ph_i,
    input  logic [RDX_W-1:0] grp_i,
    output logic             cache_we_o,
    output logic             cache_re_o,
    output logic [RDX_W-1:0] cache_row_o,
    output logic             cache_xpose_o
);
    always_comb begin
        cache_we_o    = busy_i && (ph_i == PH_FILL);
        cache_re_o    = busy_i && (ph_i == PH_DRAIN);
        cache_row_o   = busy_i ? grp_i : '0;
        cache_xpose_o = cache_re_o;
    end

    // R7: the cache port is never read and written in the same cycle
    p_cache_single_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(cache_we_o && cache_re_o));
    // R7: a drain run is preceded by the fill of the last row
    p_drain_after_fill_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(cache_re_o) |-> ($past(cache_we_o) && $past(cache_row_o) == '1));
endmodule

// File: rtl/pps_addr_gen.sv
module pps_addr_gen
    import pps_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int RDX_W  = 3,
    parameter int PASS_W = 1,
    parameter int BLK_W  = 6,
    localparam int BLKC_W = (BLK_W > 0) ? BLK_W : 1,
    localparam int LANES  = 1 << RDX_W,
    localparam int NDIG   = ADDR_W / RDX_W,
    localparam int IN_W   = ADDR_W - RDX_W
) (
    input  logic                    active_i,
    input  logic [PASS_W-1:0]       pass_i,
    input  logic [BLKC_W-1:0]       blk_i,
    input  phase_e                  ph_i,
    input  logic [RDX_W-1:0]        grp_i,
    output logic [LANES*RDX_W-1:0]  bank_o,
    output logic [LANES*IN_W-1:0]   addr_o
);
    int pos_lane, pos_grp;

    always_comb begin
        pos_lane = NDIG - 1 - 2 * int'(pass_i);
        pos_grp  = NDIG - 2 - 2 * int'(pass_i);
        if (ph_i == PH_DRAIN) begin
            pos_lane = NDIG - 2 - 2 * int'(pass_i);
            pos_grp  = NDIG - 1 - 2 * int'(pass_i);
        end
    end

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        logic [ADDR_W-1:0] word_d;
        logic [RDX_W-1:0]  skew_d;

        always_comb begin
            int bi;
            bi     = 0;
            word_d = '0;
            for (int d = 0; d < NDIG; d++) begin
                if (d == pos_lane) begin
                    word_d[d*RDX_W +: RDX_W] = RDX_W'(k);
                end else if (d == pos_grp) begin
                    word_d[d*RDX_W +: RDX_W] = grp_i;
                end else begin
                    word_d[d*RDX_W +: RDX_W] = blk_i[bi*RDX_W +: RDX_W];
                    bi = bi + 1;
                end
            end
            skew_d = '0;
            for (int d = 0; d < NDIG; d++) begin
                skew_d = skew_d + word_d[d*RDX_W +: RDX_W];
            end
        end

        assign bank_o[k*RDX_W +: RDX_W] = active_i ? skew_d : '0;
        assign addr_o[k*IN_W +: IN_W]   = active_i ? word_d[ADDR_W-1:RDX_W] : '0;
    end
endmodule

// File: rtl/ping_pong_cache_seq.sv
module ping_pong_cache_seq
    import pps_pkg::*;
#(
    parameter int ADDR_W = 12,
    localparam int RDX_W  = 3,
    localparam int LANES  = 1 << RDX_W,
    localparam int NDIG   = ADDR_W / RDX_W,
    localparam int NPASS  = NDIG / 2,
    localparam int PASS_W = (NPASS > 1) ? $clog2(NPASS) : 1,
    localparam int BLK_W  = (NDIG - 2) * RDX_W,
    localparam int BLKC_W = (BLK_W > 0) ? BLK_W : 1,
    localparam int IN_W   = ADDR_W - RDX_W
) (
    input  logic                    clk_i,
    input  logic                    rst_ni,
    input  logic                    start_i,
    output logic                    busy_o,
    output logic                    done_o,
    output logic                    proc_buf_o,
    output logic                    fill_o,
    output logic                    drain_o,
    output logic [PASS_W:0]         stage_o,
    output logic                    main_re_o,
    output logic                    main_we_o,
    output logic [LANES*RDX_W-1:0]  lane_bank_o,
    output logic [LANES*IN_W-1:0]   lane_addr_o,
    output logic                    cache_re_o,
    output logic                    cache_we_o,
    output logic [RDX_W-1:0]        cache_row_o,
    output logic                    cache_xpose_o
);
    logic              busy_w;
    logic [PASS_W-1:0] pass_w;
    logic [BLKC_W-1:0] blk_w;
    phase_e            ph_w;
    logic [RDX_W-1:0]  grp_w;

    pps_ctrl #(.RDX_W(RDX_W), .NPASS(NPASS), .PASS_W(PASS_W), .BLK_W(BLK_W)) u_ctrl (
        .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i),
        .busy_o(busy_w), .done_o(done_o), .psel_o(proc_buf_o),
        .pass_o(pass_w), .blk_o(blk_w), .ph_o(ph_w), .grp_o(grp_w)
    );

    pps_cache_ctl #(.RDX_W(RDX_W)) u_cache (
        .clk_i(clk_i), .rst_ni(rst_ni), .busy_i(busy_w), .ph_i(ph_w), .grp_i(grp_w),
        .cache_we_o(cache_we_o), .cache_re_o(cache_re_o),
        .cache_row_o(cache_row_o), .cache_xpose_o(cache_xpose_o)
    );

    pps_addr_gen #(.ADDR_W(ADDR_W), .RDX_W(RDX_W), .PASS_W(PASS_W), .BLK_W(BLK_W)) u_addr (
        .active_i(busy_w), .pass_i(pass_w), .blk_i(blk_w), .ph_i(ph_w), .grp_i(grp_w),
        .bank_o(lane_bank_o), .addr_o(lane_addr_o)
    );

    assign busy_o    = busy_w;
    assign fill_o    = busy_w && (ph_w == PH_FILL);
    assign drain_o   = busy_w && (ph_w == PH_DRAIN);
    assign main_re_o = fill_o;
    assign main_we_o = drain_o;
    assign stage_o   = busy_w ? {pass_w, ph_w == PH_DRAIN} : '0;

    logic [LANES-1:0] bank_hot;
    always_comb begin
        bank_hot = '0;
        for (int k = 0; k < LANES; k++) begin
            bank_hot[lane_bank_o[k*RDX_W +: RDX_W]] = 1'b1;
        end
    end

    // R4: the eight operands never collide on a bank
    p_banks_distinct_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        busy_o |-> ($countones(bank_hot) == LANES));
    // R3: main memory and cache roles agree with the phase
    p_phase_roles_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        busy_o |-> ((main_re_o && cache_we_o && !main_we_o && !cache_re_o) ||
                    (main_we_o && cache_re_o && !main_re_o && !cache_we_o)));
    // R1: nothing is enabled while idle
    p_idle_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !busy_o |-> !(main_re_o || main_we_o || cache_re_o || cache_we_o));
endmodule

// File: tb/sim_ping_pong_cache_seq.sv
module sim_ping_pong_cache_seq;
    localparam int AW    = 12;
    localparam int NDIG  = AW / 3;
    localparam int NPASS = NDIG / 2;
    localparam int NW    = 1 << AW;
    localparam int NBLK  = NW / 64;
    localparam int TCYC  = NPASS * NBLK * 16;
    localparam int IN_W  = AW - 3;
    localparam int PW    = (NPASS > 1) ? $clog2(NPASS) : 1;

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
    logic busy, done, pbuf, fill, drain, mre, mwe, cre, cwe, cx;
    logic [PW:0] stage;
    logic [23:0] bank;
    logic [8*IN_W-1:0] addr;
    logic [2:0] crow;

    int vectors = 0, miscompares = 0;
    bit finished = 1'b0;
    bit rd_seen [NW];
    bit wr_seen [NW];
    int cache_m [64];
    int rd_cycles;

    ping_pong_cache_seq #(.ADDR_W(AW)) u0 (
        .clk_i(clk), .rst_ni(rst_n), .start_i(start), .busy_o(busy), .done_o(done),
        .proc_buf_o(pbuf), .fill_o(fill), .drain_o(drain), .stage_o(stage),
        .main_re_o(mre), .main_we_o(mwe), .lane_bank_o(bank), .lane_addr_o(addr),
        .cache_re_o(cre), .cache_we_o(cwe), .cache_row_o(crow), .cache_xpose_o(cx)
    );

    always #5 clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int dig(input int w, input int d);
        return (w >> (3 * d)) & 7;
    endfunction

    task automatic summary;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    endtask

    // Check one busy cycle at position c of the transform
    task automatic check_cycle(input int c);
        int g, ph, p, pl, pg, mask, w0;
        g  = c % 8;
        ph = (c / 8) % 2;
        p  = c / (16 * NBLK);
        pl = (ph == 0) ? NDIG - 1 - 2 * p : NDIG - 2 - 2 * p;
        pg = (ph == 0) ? NDIG - 2 - 2 * p : NDIG - 1 - 2 * p;
        chk(busy == 1'b1, "R2 busy", int'(busy), 1);
        chk(fill == (ph == 0) && drain == (ph == 1), "R3 phase", int'(drain), ph);
        chk(mre == (ph == 0) && cwe == (ph == 0) && mwe == (ph == 1) && cre == (ph == 1),
            "R3 enables", int'({mre, cwe, mwe, cre}), ph ? 3 : 12);
        chk(int'(stage) == 2 * p + ph, "R6 stage", int'(stage), 2 * p + ph);
        chk(int'(crow) == g && int'(cx) == ph, "R7 cache row", int'(crow), g);
        mask = 0;
        w0 = 0;
        for (int k = 0; k < 8; k++) begin
            int a, b, ds, w;
            a  = int'(addr[k*IN_W +: IN_W]);
            b  = int'(bank[k*3 +: 3]);
            ds = 0;
            for (int d = 0; d < NDIG - 1; d++) ds += dig(a, d);
            w  = a * 8 + ((b - ds) & 7);
            mask |= 1 << b;
            if (k == 0) w0 = w;
            chk(dig(w, pl) == k, "R6 lane digit", dig(w, pl), k);
            chk(dig(w, pg) == g, "R6 group digit", dig(w, pg), g);
            for (int d = 0; d < NDIG; d++)
                if (d != pl && d != pg)
                    chk(dig(w, d) == dig(w0, d), "R6 shared digit", dig(w, d), dig(w0, d));
            if (ph == 0) begin
                chk(!rd_seen[w], "R8 single read", int'(rd_seen[w]), 0);
                rd_seen[w] = 1'b1;
                cache_m[g * 8 + k] = w;
            end else begin
                chk(!wr_seen[w], "R8 single write", int'(wr_seen[w]), 0);
                wr_seen[w] = 1'b1;
                chk(w == cache_m[k * 8 + g], "R7 transpose", w, cache_m[k * 8 + g]);
            end
        end
        chk(mask == 255, "R4 distinct banks / R5 mapping", mask, 255);
        if (mre) rd_cycles++;
        if (c % (16 * NBLK) == 16 * NBLK - 1) begin
            int nr, nw;
            nr = 0; nw = 0;
            for (int i = 0; i < NW; i++) begin
                nr += int'(rd_seen[i]); nw += int'(wr_seen[i]);
                rd_seen[i] = 1'b0; wr_seen[i] = 1'b0;
            end
            chk(nr == NW && nw == NW, "R8 pass coverage", nr + nw, 2 * NW);
        end
    endtask

    task automatic run_transform(input bit poke, input int exp_buf_after);
        rd_cycles = 0;
        @(negedge clk);
        start = 1'b1;
        for (int c = 0; c < TCYC; c++) begin
            @(negedge clk);
            start = poke && (c == 100 || c == 1500);
            check_cycle(c);
        end
        @(negedge clk);
        start = 1'b0;
        chk(done && !busy, "R10 done pulse", int'(done), 1);
        chk(int'(pbuf) == exp_buf_after, "R10 buffer swap", int'(pbuf), exp_buf_after);
        chk(rd_cycles == NPASS * NW / 8 && 2 * rd_cycles == NDIG * NW / 8,
            "R9 main read cycles", rd_cycles, NPASS * NW / 8);
        @(negedge clk);
        chk(!done && !busy, "R10 pulse one cycle", int'(done), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !done && !fill && !drain, "R1 idle flags", int'({busy, done, fill, drain}), 0);
        chk(!mre && !mwe && !cre && !cwe && !pbuf, "R1 enables", int'({mre, mwe, cre, cwe, pbuf}), 0);
        run_transform(1'b0, 1);
        run_transform(1'b1, 0);  // R2: start pulses mid-transform must be ignored
        finished = 1'b1;
        summary();
        $finish;
    end

    initial begin
        #(10 * 20000);
        if (!finished) begin
            miscompares++;
            $display("FAIL watchdog actual=hung expected=finished");
            summary();
            $finish;
        end
    end
endmodule